// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small fully associative store that sits beside a direct-mapped cache, on the path to the next memory level. It keeps only lines that the direct-mapped cache has thrown out. When the main cache misses, it asks the buffer for the line. If the buffer holds that line, the line goes back to the main cache and leaves the buffer. This turns a conflict miss into a short swap instead of a full memory access.

Each slot holds one line, its full line address (tag and index together, since a slot belongs to no set) and a dirty flag. Every slot has its own comparator, so all slots are searched in the same cycle. A request can carry two parts. One is a lookup of the missing line address. The other is the line the main cache is evicting. On a lookup hit, the evicted line takes the freed slot, which completes the swap. On a lookup miss, the evicted line goes into an empty slot if there is one. If every slot is full, it replaces the least recently written slot. A dirty line pushed out this way is handed to memory on a writeback stream.

Requests use valid/ready. The block lowers `req_ready` while a writeback is waiting, because one request can push out at most one line. The response is a plain pulse one cycle after the lookup is accepted and cannot be stalled. The writeback output is valid/ready: once `wb_valid` rises, address and data hold steady until `wb_ready` is seen high at a clock edge.

Top module: `victim_buffer`

## Requirements
- R1: After reset every slot is empty, `rsp_valid` and `wb_valid` are 0 and `req_ready` is 1, so any lookup misses.
- R2: An accepted request with `req_lookup`=1 gives `rsp_valid`=1 for exactly the next cycle. In that cycle `rsp_hit` is 1 only if a slot held `req_addr`, and then `rsp_data` and `rsp_dirty` are that slot's line and dirty flag. A miss returns `rsp_data`=0 and `rsp_dirty`=0.
- R3: A lookup hit removes the found line from the buffer unless the same request also supplies a line with that same address.
- R4: When a lookup hits and an evicted line comes with the request, the evicted line is stored (swap), and a later lookup of its address returns it.
- R5: When a slot is empty, an evicted line is stored without pushing out any line and without a writeback.
- R6: When all slots are full and the evicted address matches no slot and the lookup misses, the slot replaced is the one written least recently.
- R7: A replaced line that is dirty appears on `wb_valid`/`wb_addr`/`wb_data` the cycle after the request. A replaced clean line is dropped without a writeback.
- R8: While `wb_valid`=1 and `wb_ready`=0, `wb_addr` and `wb_data` hold steady and `req_ready` is 0. `wb_valid` clears after an edge with `wb_ready`=1.
- R9: An address is never held in two slots. An evicted line whose address is already present overwrites that slot, with dirty set to the OR of the old and new flags. If the lookup hit another slot in the same cycle, that other slot is emptied.
- R10: An accepted request with `req_lookup`=0 gives no response and empties no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted at the edge when high together with valid |
| req_lookup | input | 1 | Request includes a lookup of `req_addr` |
| req_addr | input | ADDR_W | Line address the main cache missed on |
| req_ev_valid | input | 1 | Request carries an evicted line |
| req_ev_addr | input | ADDR_W | Full line address of the evicted line |
| req_ev_dirty | input | 1 | Evicted line is modified |
| req_ev_data | input | LINE_W | Evicted line contents |
| rsp_valid | output | 1 | Lookup result pulse |
| rsp_hit | output | 1 | Lookup found the line |
| rsp_dirty | output | 1 | Returned line is modified |
| rsp_data | output | LINE_W | Returned line contents |
| wb_valid | output | 1 | Dirty pushed-out line waiting for memory |
| wb_ready | input | 1 | Memory takes the writeback |
| wb_addr | output | ADDR_W | Writeback line address |
| wb_data | output | LINE_W | Writeback line contents |

## Verification
The properties assume that all inputs are at known levels from the first edge. They also assume that `wb_ready` is the only way a pending writeback is released, so a held `wb_valid` is a real stall. The stimulus raises `req_valid` only while `req_ready` is high and drives every field on each request. It draws addresses from a pool of eight lines so that hits, repeat inserts, same-address lookup-and-insert pairs and full-buffer replacement happen often. It also holds `wb_ready` low for a random number of cycles, so stalled writebacks are exercised as well.

// File: rtl/vc_pkg.sv
`timescale 1ns/1ps
package vc_pkg;
  // Where the evicted line of a request is written
  typedef enum logic [2:0] {
    TGT_NONE,   // no evicted line supplied
    TGT_MATCH,  // same address already present: overwrite in place
    TGT_HIT,    // take the slot the lookup hit frees
    TGT_FREE,   // take an empty slot
    TGT_LRU     // replace the least recently written slot
  } vc_target_e;
endpackage

// File: rtl/vc_match.sv
`timescale 1ns/1ps
// Parallel address compare across all slots
module vc_match #(
  parameter int N  = 4,
  parameter int AW = 12,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         ent_valid,
  input  logic [N-1:0][AW-1:0] ent_addr,
  input  logic [AW-1:0]        key,
  output logic                 found,
  output logic [IW-1:0]        found_idx
);
  always_comb begin
    found     = 1'b0;
    found_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (ent_valid[i] && (ent_addr[i] == key)) begin
        found     = 1'b1;
        found_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vc_lru.sv
`timescale 1ns/1ps
// Recency ranks: 0 = most recently written, N-1 = least recently written
module vc_lru #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] oldest_idx
);
  logic [IW-1:0] rank [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)             rank[i] <= '0;
        else if (rank[i] < rank[touch_idx])  rank[i] <= rank[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < N; i++)
      if (rank[i] == IW'(N - 1)) oldest_idx = IW'(i);
  end
endmodule

// File: rtl/victim_buffer.sv
`timescale 1ns/1ps
module victim_buffer
  import vc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 12,
  parameter int LINE_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_lookup,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_ev_valid,
  input  logic [ADDR_W-1:0] req_ev_addr,
  input  logic              req_ev_dirty,
  input  logic [LINE_W-1:0] req_ev_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_dirty,
  output logic [LINE_W-1:0] rsp_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  // Slot storage
  logic [NUM_ENTRIES-1:0]             e_valid;
  logic [NUM_ENTRIES-1:0]             e_dirty;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] e_addr;
  logic [NUM_ENTRIES-1:0][LINE_W-1:0] e_data;

  logic          accept, do_hit, clear_hit, push_out;
  logic          lk_found, ev_found, free_any;
  logic [IW-1:0] lk_idx, ev_idx, free_idx, oldest_idx, tgt_idx;
  vc_target_e    tgt_src;

  assign req_ready = !wb_valid;
  assign accept    = req_valid && req_ready;

  vc_match #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_lk_match (
    .ent_valid(e_valid), .ent_addr(e_addr), .key(req_addr),
    .found(lk_found), .found_idx(lk_idx));

  vc_match #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_ev_match (
    .ent_valid(e_valid), .ent_addr(e_addr), .key(req_ev_addr),
    .found(ev_found), .found_idx(ev_idx));

  vc_lru #(.N(NUM_ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch(tgt_src != TGT_NONE), .touch_idx(tgt_idx),
    .oldest_idx(oldest_idx));

  // Lowest-numbered empty slot
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!e_valid[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  assign do_hit = accept && req_lookup && lk_found;

  // Placement of the evicted line; an existing copy always wins
  always_comb begin
    tgt_src = TGT_NONE;
    tgt_idx = '0;
    if (accept && req_ev_valid) begin
      if (ev_found) begin
        tgt_src = TGT_MATCH; tgt_idx = ev_idx;
      end else if (do_hit) begin
        tgt_src = TGT_HIT;   tgt_idx = lk_idx;
      end else if (free_any) begin
        tgt_src = TGT_FREE;  tgt_idx = free_idx;
      end else begin
        tgt_src = TGT_LRU;   tgt_idx = oldest_idx;
      end
    end
  end

  assign push_out  = (tgt_src == TGT_LRU) && e_dirty[oldest_idx];
  assign clear_hit = do_hit && !((tgt_src != TGT_NONE) && (tgt_idx == lk_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= '0;
      e_dirty <= '0;
      e_addr  <= '0;
      e_data  <= '0;
    end else begin
      if (clear_hit) begin
        e_valid[lk_idx] <= 1'b0;
        e_dirty[lk_idx] <= 1'b0;
      end
      if (tgt_src != TGT_NONE) begin
        e_valid[tgt_idx] <= 1'b1;
        e_addr[tgt_idx]  <= req_ev_addr;
        e_data[tgt_idx]  <= req_ev_data;
        e_dirty[tgt_idx] <= req_ev_dirty || ((tgt_src == TGT_MATCH) && e_dirty[tgt_idx]);
      end
    end
  end

  // Registered lookup response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept && req_lookup;
      rsp_hit   <= do_hit;
      rsp_dirty <= do_hit && e_dirty[lk_idx];
      rsp_data  <= do_hit ? e_data[lk_idx] : '0;
    end
  end

  // Writeback holding register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
    end else if (push_out) begin
      wb_valid <= 1'b1;
      wb_addr  <= e_addr[oldest_idx];
      wb_data  <= e_data[oldest_idx];
    end else if (wb_ready) begin
      wb_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vc_checker.sv
`timescale 1ns/1ps
module vc_checker #(
  parameter int N  = 4,
  parameter int AW = 12,
  parameter int LW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_lookup,
  input logic                 req_ev_valid,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic                 wb_valid,
  input logic                 wb_ready,
  input logic [AW-1:0]        wb_addr,
  input logic [LW-1:0]        wb_data,
  input logic [N-1:0]         ent_valid,
  input logic [N-1:0][AW-1:0] ent_addr
);
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (ent_valid[i] && ent_valid[j] && ent_addr[i] == ent_addr[j]) dup = 1'b1;
  end

  // R2
  rsp_after_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_lookup) |=> rsp_valid);

  // R10
  no_rsp_without_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_lookup) |=> !rsp_valid);

  // R2
  hit_inside_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

  // R7
  wb_from_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(req_valid && req_ready && req_ev_valid));

  // R9
  no_duplicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dup);
endmodule

bind victim_buffer vc_checker #(.N(NUM_ENTRIES), .AW(ADDR_W), .LW(LINE_W)) u_vc_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_lookup(req_lookup), .req_ev_valid(req_ev_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
  .wb_data(wb_data), .ent_valid(e_valid), .ent_addr(e_addr));

// File: tb/tb_victim_buffer.sv
`timescale 1ns/1ps
module tb_victim_buffer;
  localparam int N  = 4;
  localparam int AW = 12;
  localparam int LW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_lookup = 1'b0, req_ev_valid = 1'b0, req_ev_dirty = 1'b0;
  logic [AW-1:0] req_addr = '0, req_ev_addr = '0;
  logic [LW-1:0] req_ev_data = '0;
  logic wb_ready = 1'b0;
  logic req_ready, rsp_valid, rsp_hit, rsp_dirty, wb_valid;
  logic [LW-1:0] rsp_data, wb_data;
  logic [AW-1:0] wb_addr;

  always #5 clk = ~clk;

  victim_buffer #(.NUM_ENTRIES(N), .ADDR_W(AW), .LINE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lookup(req_lookup), .req_addr(req_addr), .req_ev_valid(req_ev_valid),
    .req_ev_addr(req_ev_addr), .req_ev_dirty(req_ev_dirty), .req_ev_data(req_ev_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty), .rsp_data(rsp_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data));

  int n_checks = 0;
  int n_fail = 0;

  // Reference contents: slot position is irrelevant, only set membership and write order
  bit          m_v  [N];
  logic [AW-1:0] m_a [N];
  logic [LW-1:0] m_d [N];
  bit          m_dt [N];
  int          m_st [N];
  int          stamp = 0;

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] pool_addr(input int k);
    return AW'(12'h140 + 12'(k) * 12'h020);
  endfunction

  task automatic txn(input bit lk, input logic [AW-1:0] a, input bit ev,
                     input logic [AW-1:0] ea, input bit ed, input logic [LW-1:0] edata,
                     input int hold);
    int hi, mi, fi, oi;
    bit exp_hit, exp_dt, exp_wb;
    logic [LW-1:0] exp_d, exp_wd;
    logic [AW-1:0] exp_wa;
    hi = -1; mi = -1; fi = -1; oi = -1;
    exp_wb = 0; exp_wd = '0; exp_wa = '0;
    for (int i = 0; i < N; i++) begin
      if (lk && m_v[i] && m_a[i] == a) hi = i;
      if (ev && m_v[i] && m_a[i] == ea) mi = i;
    end
    exp_hit = (hi >= 0);
    exp_d   = exp_hit ? m_d[hi] : '0;
    exp_dt  = exp_hit ? m_dt[hi] : 1'b0;
    if (ev) begin
      if (mi >= 0) begin
        m_d[mi] = edata; m_dt[mi] = m_dt[mi] | ed; m_st[mi] = stamp++;
        if (exp_hit && hi != mi) m_v[hi] = 0;
      end else if (exp_hit) begin
        m_a[hi] = ea; m_d[hi] = edata; m_dt[hi] = ed; m_st[hi] = stamp++;
      end else begin
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) fi = i;
        if (fi < 0) begin
          for (int i = 0; i < N; i++) if (oi < 0 || m_st[i] < m_st[oi]) oi = i;
          fi = oi;
          if (m_dt[oi]) begin exp_wb = 1; exp_wa = m_a[oi]; exp_wd = m_d[oi]; end
        end
        m_v[fi] = 1; m_a[fi] = ea; m_d[fi] = edata; m_dt[fi] = ed; m_st[fi] = stamp++;
      end
    end else if (exp_hit) begin
      m_v[hi] = 0;
    end

    @(negedge clk);
    check("R8", "req_ready before request", req_ready, 1);
    req_valid = 1; req_lookup = lk; req_addr = a; req_ev_valid = ev;
    req_ev_addr = ea; req_ev_dirty = ed; req_ev_data = edata;
    @(negedge clk);
    req_valid = 0;
    check(lk ? "R2" : "R10", "rsp_valid", rsp_valid, lk);
    if (lk) begin
      check("R2", "rsp_hit", rsp_hit, exp_hit);
      check("R2", "rsp_data", rsp_data, exp_d);
      check("R2", "rsp_dirty", rsp_dirty, exp_dt);
    end
    check("R7", "wb_valid", wb_valid, exp_wb);
    if (exp_wb) begin
      check("R7", "wb_addr", wb_addr, exp_wa);
      check("R7", "wb_data", wb_data, exp_wd);
      check("R8", "req_ready during writeback", req_ready, 0);
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        check("R8", "wb_valid held", wb_valid, 1);
        check("R8", "wb_addr held", wb_addr, exp_wa);
        check("R8", "wb_data held", wb_data, exp_wd);
        check("R8", "req_ready stalled", req_ready, 0);
      end
      wb_ready = 1;
      @(negedge clk);
      wb_ready = 0;
      check("R8", "wb_valid released", wb_valid, 0);
    end
  endtask

  task automatic lookup(input logic [AW-1:0] a);
    txn(1, a, 0, '0, 0, '0, 0);
  endtask

  task automatic insert(input logic [AW-1:0] ea, input bit ed, input logic [LW-1:0] d, input int hold);
    txn(0, '0, 1, ea, ed, d, hold);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_dt[i] = 0; m_st[i] = 0; m_a[i] = '0; m_d[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "rsp_valid after reset", rsp_valid, 0);
    check("R1", "wb_valid after reset", wb_valid, 0);
    check("R1", "req_ready after reset", req_ready, 1);
    lookup(pool_addr(0));                        // R1 empty buffer misses

    // R5 fill empty slots, no writeback
    for (int k = 0; k < N; k++) insert(pool_addr(k), k == 0, 32'hA000_0000 + k, 0);
    // R6 full: oldest (pool 0, dirty) replaced -> R7 writeback with stall
    insert(pool_addr(4), 0, 32'hA000_0004, 3);
    lookup(pool_addr(0));                        // R6 oldest gone
    // R7 clean oldest (pool 1) dropped, no writeback
    insert(pool_addr(5), 1, 32'hA000_0005, 0);
    // R3 hit removes line; second lookup misses
    lookup(pool_addr(2));
    lookup(pool_addr(2));
    // R4 swap: hit on pool 3 while evicting pool 6
    txn(1, pool_addr(3), 1, pool_addr(6), 1, 32'hB000_0006, 0);
    lookup(pool_addr(6));
    // R9 re-insert an existing address, then hit it once
    insert(pool_addr(4), 1, 32'hC000_0004, 0);
    insert(pool_addr(4), 0, 32'hC100_0004, 0);
    lookup(pool_addr(4));
    lookup(pool_addr(4));
    // R9 hit one slot while evicting an address present in another
    insert(pool_addr(1), 0, 32'hD000_0001, 0);
    txn(1, pool_addr(5), 1, pool_addr(1), 1, 32'hD100_0001, 0);
    lookup(pool_addr(5));
    lookup(pool_addr(1));
    // R3 lookup and evict of the same address keeps one copy
    insert(pool_addr(7), 0, 32'hE000_0007, 0);
    txn(1, pool_addr(7), 1, pool_addr(7), 0, 32'hE100_0007, 0);
    lookup(pool_addr(7));
    // R10 insert-only request leaves other lines in place
    insert(pool_addr(2), 0, 32'hF000_0002, 0);
    lookup(pool_addr(2));

    // Random mix
    for (int t = 0; t < 600; t++) begin
      bit lk, ev, ed;
      lk = ($urandom % 4) != 0;
      ev = ($urandom % 4) != 0;
      ed = $urandom % 2;
      txn(lk, pool_addr(int'($urandom % 8)), ev, pool_addr(int'($urandom % 8)), ed,
          $urandom, int'($urandom % 4));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule